// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the byte-wide programming front end of one eight-line interrupt controller slice. A host writes and reads it through two addresses, selected by a single address bit. A start word written to address 0 opens a short setup sequence, and the words that follow at address 1 set the vector base and, optionally, the nesting and automatic end-of-interrupt modes. Outside that sequence, address 1 holds the line mask. Address 0 accepts two kinds of word, told apart by bit pattern. Control words choose which register is read back, arm a poll, or set special masking. Command words issue end-of-interrupt variants and priority rotation.

The block holds only configuration. The request and in-service registers belong to the priority resolver next to it. The resolver feeds both registers back in, together with its current winner. In return the block sends the resolver one-cycle clear pulses for in-service and request bits. It also pulses a signal that tells the resolver to forget the previous input levels. Reads return their data one cycle after the read strobe. A read taken while a poll is armed returns the winning line and acknowledges it.

Top module: `pic_cmd_regs`

## Requirements
- R1: After reset the slice is in normal mode: mask, vector base, rotation offset and every mode flag are zero, and no poll is armed.
- R2: A write to address 0 with bit 4 set starts setup. Bit 0 records whether a fourth word follows. Mask, rotation offset, special mask and read select are cleared, and `lvl_clr_o` pulses for one cycle. When bit 0 is clear, auto-EOI and nesting are cleared as well.
- R3: During setup, the first address-1 write loads the vector base from bits 7..3. The second is discarded: the mask and the base keep their values. It returns the slice to normal mode, or moves it to the fourth-word step if one was announced. `init_o` is high from the start word until the sequence ends.
- R4: In the fourth-word step, bit 4 sets nesting and bit 1 sets auto-EOI, and the slice returns to normal mode.
- R5: In normal mode, an address-1 write loads the mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 arms a poll. When bit 1 is set, bit 0 selects the read-back register (1 = in-service, 0 = request); otherwise the selection is kept. When bit 6 is set, bit 5 becomes the special-mask flag; otherwise that flag is kept.
- R7: Any other address-0 write carries a command code in bits 7..5. Code 0 clears the rotate-on-auto-EOI flag and code 4 sets it. Code 6 sets the rotation offset to (bits 2..0 + 1) mod 8. Code 2 changes nothing.
- R8: A read strobe raises `rvalid_o` on the next cycle. The data is then the mask for address 1. For address 0 it is the in-service or request input, chosen by the read select.
- R9: Codes 1 and 5 clear the in-service line of highest priority. Priority is scanned from the line equal to the rotation offset upward, wrapping around. Code 5 then sets the offset to that line + 1, and with nothing in service neither code acts. Code 3 clears the line named by bits 2..0, and code 7 does the same and also sets the offset to that line + 1. Each clear is a one-cycle pulse on `isr_clr_o`, one-hot by line.
- R10: A read with a poll armed returns the winning line in bits 2..0 and pulses that line on both `isr_clr_o` and `irr_clr_o`. With no winner it returns 7 and pulses nothing. Either way the poll is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| isr_in | input | 8 | In-service bits from the resolver |
| irr_in | input | 8 | Request bits from the resolver |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line number |
| rdata | output | 8 | Read data |
| rvalid_o | output | 1 | Read data valid |
| mask_o | output | 8 | Line mask |
| base_o | output | 5 | Vector base (upper five bits) |
| rot_o | output | 3 | Rotation offset (lowest-priority line + 1) |
| aeoi_o | output | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| nest_o | output | 1 | Special nesting mode |
| smask_o | output | 1 | Special mask mode |
| rsel_o | output | 1 | Read select (1 = in-service) |
| poll_o | output | 1 | Poll armed |
| init_o | output | 1 | Setup sequence in progress |
| isr_clr_o | output | 8 | In-service clear pulse |
| irr_clr_o | output | 8 | Request clear pulse |
| lvl_clr_o | output | 1 | Previous-level clear pulse |

## Verification
Every write takes effect at the clock edge where it is sampled. Configuration outputs and the clear pulses are therefore due one cycle after the strobe. The pulses last only that one cycle, so the bench samples them at the falling edge right after the capturing edge, before the next rising edge can clear them. Read data and `rvalid_o` are also due one cycle after the read strobe. A monitor pops the expected value at the falling edge where `rvalid_o` is high. The bench drives the resolver inputs in advance and holds them steady, so the priority scan and the poll winner are fixed when the edge arrives.

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs #(
  parameter int LINES = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] isr_in,
  input  logic [LINES-1:0] irr_in,
  input  logic             win_valid,
  input  logic [$clog2(LINES)-1:0] win_line,
  output logic [DW-1:0]    rdata,
  output logic             rvalid_o,
  output logic [LINES-1:0] mask_o,
  output logic [DW-4:0]    base_o,
  output logic [$clog2(LINES)-1:0] rot_o,
  output logic             aeoi_o,
  output logic             rot_aeoi_o,
  output logic             nest_o,
  output logic             smask_o,
  output logic             rsel_o,
  output logic             poll_o,
  output logic             init_o,
  output logic [LINES-1:0] isr_clr_o,
  output logic [LINES-1:0] irr_clr_o,
  output logic             lvl_clr_o
);
  localparam int LW = $clog2(LINES);
  localparam logic [LW-1:0] SPUR = LW'(LINES - 1);

  typedef enum logic [1:0] {S_RUN, S_BASE, S_SKIP, S_MODE} st_t;
  st_t st;
  logic need4;

  wire wr0   = wr_en & ~addr;
  wire wr1   = wr_en & addr;
  wire start = wr0 & wdata[4];
  wire ctl   = wr0 & ~wdata[4] & wdata[3];
  wire cmd   = wr0 & ~wdata[4] & ~wdata[3];
  wire [2:0] code = wdata[7:5];
  wire [LW-1:0] named = wdata[LW-1:0];
  wire poll_rd = rd_en & poll_o;

  assign init_o = (st != S_RUN);

  logic          hi_vld;
  logic [LW-1:0] hi_line;
  logic [LW-1:0] idx;
  always_comb begin
    hi_vld  = 1'b0;
    hi_line = '0;
    idx     = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      idx = rot_o + LW'(i);
      if (isr_in[idx]) begin
        hi_vld  = 1'b1;
        hi_line = idx;
      end
    end
  end

  logic [LINES-1:0] eoi_clr, poll_clr;
  always_comb begin
    eoi_clr = '0;
    if (cmd) begin
      case (code)
        3'd1, 3'd5: if (hi_vld) eoi_clr = LINES'(1) << hi_line;
        3'd3, 3'd7: eoi_clr = LINES'(1) << named;
        default:    eoi_clr = '0;
      endcase
    end
  end
  assign poll_clr = (poll_rd && win_valid) ? (LINES'(1) << win_line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      need4      <= 1'b0;
      mask_o     <= '0;
      base_o     <= '0;
      rot_o      <= '0;
      aeoi_o     <= 1'b0;
      rot_aeoi_o <= 1'b0;
      nest_o     <= 1'b0;
      smask_o    <= 1'b0;
      rsel_o     <= 1'b0;
      poll_o     <= 1'b0;
      isr_clr_o  <= '0;
      irr_clr_o  <= '0;
      lvl_clr_o  <= 1'b0;
      rdata      <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      isr_clr_o <= eoi_clr | poll_clr;
      irr_clr_o <= poll_clr;
      lvl_clr_o <= start;
      rvalid_o  <= rd_en;

      if (rd_en) begin
        if (poll_o) begin
          rdata  <= win_valid ? DW'(win_line) : DW'(SPUR);
          poll_o <= 1'b0;
        end else if (addr) begin
          rdata <= DW'(mask_o);
        end else begin
          rdata <= DW'(rsel_o ? isr_in : irr_in);
        end
      end

      if (start) begin
        need4   <= wdata[0];
        mask_o  <= '0;
        rot_o   <= '0;
        smask_o <= 1'b0;
        rsel_o  <= 1'b0;
        if (!wdata[0]) begin
          aeoi_o <= 1'b0;
          nest_o <= 1'b0;
        end
        st <= S_BASE;
      end else if (ctl) begin
        if (wdata[2]) poll_o  <= 1'b1;
        if (wdata[1]) rsel_o  <= wdata[0];
        if (wdata[6]) smask_o <= wdata[5];
      end else if (cmd) begin
        case (code)
          3'd0, 3'd4: rot_aeoi_o <= code[2];
          3'd5:       if (hi_vld) rot_o <= hi_line + LW'(1);
          3'd6, 3'd7: rot_o <= named + LW'(1);
          default:    ;
        endcase
      end

      if (wr1) begin
        case (st)
          S_RUN:  mask_o <= wdata[LINES-1:0];
          S_BASE: begin
            base_o <= wdata[DW-1:3];
            st     <= S_SKIP;
          end
          S_SKIP: st <= need4 ? S_MODE : S_RUN;
          S_MODE: begin
            nest_o <= wdata[4];
            aeoi_o <= wdata[1];
            st     <= S_RUN;
          end
          default: st <= S_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_cmd_regs_chk.sv
module pic_cmd_regs_chk #(
  parameter int LINES = 8,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic [LINES-1:0] mask_o,
  input logic [$clog2(LINES)-1:0] rot_o,
  input logic             smask_o,
  input logic             rsel_o,
  input logic             poll_o,
  input logic             init_o,
  input logic             rvalid_o,
  input logic [LINES-1:0] isr_clr_o,
  input logic             lvl_clr_o
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (init_o && mask_o == '0 && rot_o == '0 && !smask_o && !rsel_o && lvl_clr_o));

  assert_lvl_in_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_clr_o |-> init_o);

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !init_o) |=> (mask_o == $past(wdata[LINES-1:0])));

  assert_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_o);

  assert_no_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid_o);

  assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $onehot0(isr_clr_o));

  assert_poll_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_o && !wr_en) |=> !poll_o);
endmodule

bind pic_cmd_regs pic_cmd_regs_chk #(.LINES(LINES), .DW(DW)) u_chk (.*);

// File: tb/sim_pic_cmd_regs.sv
`timescale 1ns/1ps
module sim_pic_cmd_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, isr_in = '0, irr_in = '0;
  logic win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rdata, mask_o, isr_clr_o, irr_clr_o;
  logic [4:0] base_o;
  logic [2:0] rot_o;
  logic rvalid_o, aeoi_o, rot_aeoi_o, nest_o, smask_o, rsel_o, poll_o, init_o, lvl_clr_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pic_cmd_regs u0 (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] e, string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) chk("R8 unexpected read data", 16'(rdata), 16'hffff);
      else chk(tag_q.pop_front(), 16'(rdata), 16'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) chk("R8 missing read data", 16'(exp_q.size()), 16'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", 16'(mask_o), 0);
    chk("R1 base", 16'(base_o), 0);
    chk("R1 rot", 16'(rot_o), 0);
    chk("R1 flags", 16'({aeoi_o, rot_aeoi_o, nest_o, smask_o, rsel_o, poll_o, init_o}), 0);

    wr(0, 8'h11);
    chk("R2 init after start", 16'(init_o), 1);
    chk("R2 level clear pulse", 16'(lvl_clr_o), 1);
    wr(1, 8'h48);
    chk("R3 base", 16'(base_o), 16'h09);
    chk("R3 still in setup", 16'(init_o), 1);
    wr(1, 8'h00);
    chk("R3 fourth word expected", 16'(init_o), 1);
    chk("R3 skipped word ignored", 16'({base_o, mask_o}), 16'({5'h09, 8'h00}));
    wr(1, 8'h12);
    chk("R4 nest and aeoi", 16'({nest_o, aeoi_o}), 16'b11);
    chk("R4 back to normal", 16'(init_o), 0);
    wr(1, 8'hA5);
    chk("R5 mask load", 16'(mask_o), 16'hA5);
    rd(1, 8'hA5, "R8 read mask");

    wr(0, 8'h10);
    chk("R2 mask cleared", 16'(mask_o), 0);
    chk("R2 modes cleared without fourth word", 16'({nest_o, aeoi_o}), 0);
    wr(1, 8'h20);
    chk("R3 base second setup", 16'(base_o), 16'h04);
    wr(1, 8'hFF);
    chk("R3 ends without fourth word", 16'(init_o), 0);
    chk("R3 skipped word leaves mask and base", 16'({base_o, mask_o}), 16'({5'h04, 8'h00}));
    wr(1, 8'h3C);
    chk("R5 mask reload", 16'(mask_o), 16'h3C);

    isr_in = 8'h24; irr_in = 8'h81;
    wr(0, 8'h0B);
    chk("R6 read select set", 16'(rsel_o), 1);
    rd(0, 8'h24, "R8 read in-service");
    wr(0, 8'h09);
    chk("R6 select kept when bit1 clear", 16'(rsel_o), 1);
    wr(0, 8'h0A);
    rd(0, 8'h81, "R8 read request");
    wr(0, 8'h68);
    chk("R6 special mask set", 16'(smask_o), 1);
    wr(0, 8'h28);
    chk("R6 special mask kept when bit6 clear", 16'(smask_o), 1);
    wr(0, 8'h48);
    chk("R6 special mask cleared", 16'(smask_o), 0);

    wr(0, 8'h80);
    chk("R7 rotate-on-aeoi set", 16'(rot_aeoi_o), 1);
    wr(0, 8'h40);
    chk("R7 code 2 no effect", 16'({rot_aeoi_o, rot_o, isr_clr_o}), 16'({1'b1, 3'd0, 8'h00}));
    wr(0, 8'h00);
    chk("R7 rotate-on-aeoi cleared", 16'(rot_aeoi_o), 0);
    wr(0, 8'hC3);
    chk("R7 set offset", 16'(rot_o), 4);

    isr_in = 8'h0A;
    wr(0, 8'h20);
    chk("R9 nonspecific with offset 4", 16'(isr_clr_o), 16'h02);
    chk("R9 nonspecific keeps offset", 16'(rot_o), 4);
    wr(0, 8'hA0);
    chk("R9 rotating eoi clear", 16'(isr_clr_o), 16'h02);
    chk("R9 rotating eoi offset", 16'(rot_o), 2);
    wr(0, 8'h20);
    chk("R9 nonspecific with offset 2", 16'(isr_clr_o), 16'h08);
    wr(0, 8'h65);
    chk("R9 specific clear", 16'(isr_clr_o), 16'h20);
    wr(0, 8'hE6);
    chk("R9 specific rotate clear", 16'(isr_clr_o), 16'h40);
    chk("R9 specific rotate offset", 16'(rot_o), 7);
    isr_in = 8'h00;
    wr(0, 8'hA0);
    chk("R9 empty in-service no clear", 16'({rot_o, isr_clr_o}), 16'({3'd7, 8'h00}));

    win_valid = 1'b1; win_line = 3'd5;
    wr(0, 8'h0C);
    chk("R6 poll armed", 16'(poll_o), 1);
    rd(0, 8'h05, "R10 poll winner");
    chk("R10 poll clears in-service", 16'(isr_clr_o), 16'h20);
    chk("R10 poll clears request", 16'(irr_clr_o), 16'h20);
    chk("R10 poll disarmed", 16'(poll_o), 0);
    rd(0, 8'h81, "R8 normal read after poll");
    win_valid = 1'b0;
    wr(0, 8'h0C);
    rd(0, 8'h07, "R10 poll with no winner");
    chk("R10 no clear without winner", 16'({isr_clr_o, irr_clr_o}), 0);
    chk("R10 poll disarmed after empty", 16'(poll_o), 0);
    rd(1, 8'h3C, "R8 mask after poll");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule